// File: doc/BRIEF.md
# Cluster Control Unit Register Block

This block is the register front end of a multi-core cluster control unit. It occupies a 256-byte window on a simple register bus that has one access strobe, a write enable, a byte address, write data and read data. Every access completes in one cycle, and the read data is registered so that it appears on the cycle after the request.

The block holds one writable item, a single enable bit. It also reports a read-only configuration word, which is computed at elaboration time from the number of cores in the cluster. The word carries one presence bit per core, starting at bit 4, and the core count minus one in the low bits.

Several other word offsets are decoded but carry no function:
- power status
- invalidate-all
- the two address-filter bounds
- the two access-control words

These offsets, and every offset not listed, read as zero and ignore writes, so that software which touches them does no harm.

Top module: `clu_regblk`

## Requirements
- R1: After reset, the enable bit is 0 and the read data output is 0.
- R2: A write to word offset 0x00 stores bit 0 of the write data and discards bits 31:1. A read of offset 0x00 returns the stored bit in bit 0, with bits 31:1 zero.
- R3: A read of offset 0x04 returns the configuration word. Bits 4 to 4+N-1 are ones, bits 1:0 hold N-1, and all other bits are zero, where N is the core count. A write to 0x04 changes neither that word nor the enable bit.
- R4: Offsets 0x08 (power status) and 0x0C (invalidate-all) read as zero, and writes to them leave the enable bit unchanged.
- R5: Offsets 0x40 and 0x44 (filter bounds) read as zero, and writes to them leave the enable bit unchanged.
- R6: Offsets 0x50 and 0x54, and every other offset not named in R2 to R5, read as zero, and writes to them leave the enable bit unchanged.
- R7: Read data is valid on the clock edge after a read request. In a cycle that follows any cycle without a read request (idle or write), the read data is zero.
- R8: The core count parameter accepts 1 to 4, defaults to 1, and any other value stops elaboration.
- R9: Decoding uses address bits 7:2 only. Bits 1:0 are ignored, so 0x05 reaches the same register as 0x04.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_sel | input | 1 | Access request for this cycle |
| bus_we | input | 1 | 1 = write, 0 = read (qualified by bus_sel) |
| bus_addr | input | 8 | Byte address within the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |

## Verification
The assertions assume that bus_sel, bus_we and bus_addr are known and stable at each rising edge, and that at most one access occurs per cycle, as the bus protocol requires. They also assume that nothing is checked while the internal reset is asserted. The bench drives every input on the falling edge and issues one request per cycle. It sends no traffic until the synchronized reset has been released for several cycles. Misaligned addresses are driven on purpose, because R9 defines that they fold onto the aligned word.

// File: rtl/clu_regblk_pkg.sv
package clu_regblk_pkg;

  // Kinds of register slot that the decoder can select
  typedef enum logic [2:0] {
    SLOT_ENABLE,
    SLOT_CONFIG,
    SLOT_POWER,
    SLOT_INVAL,
    SLOT_FILTER,
    SLOT_ACCESS,
    SLOT_NONE
  } slot_e;

  // Word indices (byte offset / 4) of the decoded slots
  localparam logic [5:0] WIX_ENABLE   = 6'h00;
  localparam logic [5:0] WIX_CONFIG   = 6'h01;
  localparam logic [5:0] WIX_POWER    = 6'h02;
  localparam logic [5:0] WIX_INVAL    = 6'h03;
  localparam logic [5:0] WIX_FILT_LO  = 6'h10;
  localparam logic [5:0] WIX_FILT_HI  = 6'h11;
  localparam logic [5:0] WIX_ACC_SEC  = 6'h14;
  localparam logic [5:0] WIX_ACC_NSEC = 6'h15;

endpackage

// File: rtl/clu_rst_sync.sv
module clu_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/clu_addr_decode.sv
module clu_addr_decode
  import clu_regblk_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  output slot_e             slot
);

  localparam int WIX_W = ADDR_W - 2;

  logic [WIX_W-1:0] wix;
  logic [1:0]       unused_byte_lane;

  // R9: byte lane bits do not take part in decoding
  assign wix              = addr[ADDR_W-1:2];
  assign unused_byte_lane = addr[1:0];

  always_comb begin
    case (wix)
      WIX_ENABLE:                slot = SLOT_ENABLE;
      WIX_CONFIG:                slot = SLOT_CONFIG;
      WIX_POWER:                 slot = SLOT_POWER;
      WIX_INVAL:                 slot = SLOT_INVAL;
      WIX_FILT_LO, WIX_FILT_HI:  slot = SLOT_FILTER;
      WIX_ACC_SEC, WIX_ACC_NSEC: slot = SLOT_ACCESS;
      default:                   slot = SLOT_NONE;
    endcase
  end

endmodule

// File: rtl/clu_cfg_word.sv
module clu_cfg_word #(
  parameter int NUM_CORES = 1,
  parameter int MAX_CORES = 4,
  parameter int DATA_W    = 32,
  parameter int MASK_LSB  = 4
) (
  output logic [DATA_W-1:0] cfg_word
);

  localparam int PAD_W = DATA_W - MASK_LSB - MAX_CORES;
  localparam logic [MASK_LSB-1:0] COUNT_FIELD = MASK_LSB'(NUM_CORES - 1);

  // R8: core count limited to 1..MAX_CORES
  if (NUM_CORES < 1 || NUM_CORES > MAX_CORES) begin : g_bad_count
    $error("clu_cfg_word: NUM_CORES out of range");
  end

  logic [MAX_CORES-1:0] presence;

  for (genvar c = 0; c < MAX_CORES; c++) begin : g_core
    if (c < NUM_CORES) begin : g_on
      assign presence[c] = 1'b1;
    end else begin : g_off
      assign presence[c] = 1'b0;
    end
  end

  assign cfg_word = {{PAD_W{1'b0}}, presence, COUNT_FIELD};

endmodule

// File: rtl/clu_regblk.sv
module clu_regblk
  import clu_regblk_pkg::*;
#(
  parameter int NUM_CORES = 1,
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata
);

  localparam int MAX_CORES = 4;

  logic              rst_sync_n;
  slot_e             slot;
  logic [DATA_W-1:0] cfg_word;
  logic              rd_req;
  logic              wr_req;
  logic              enable_q;
  logic              enable_d;
  logic              enable_ce;
  logic [DATA_W-1:0] rdata_q;
  logic [DATA_W-1:0] rdata_d;
  logic [DATA_W-2:0] unused_wdata_hi;

  clu_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  clu_addr_decode #(.ADDR_W(ADDR_W)) i_decode (
    .addr (bus_addr),
    .slot (slot)
  );

  clu_cfg_word #(
    .NUM_CORES (NUM_CORES),
    .MAX_CORES (MAX_CORES),
    .DATA_W    (DATA_W),
    .MASK_LSB  (4)
  ) i_cfg (
    .cfg_word (cfg_word)
  );

  assign rd_req          = bus_sel && !bus_we;
  assign wr_req          = bus_sel && bus_we;
  assign unused_wdata_hi = bus_wdata[DATA_W-1:1];

  // Enable bit: next state
  always_comb begin
    enable_ce = wr_req && (slot == SLOT_ENABLE);
    enable_d  = bus_wdata[0];
  end

  // Enable bit: register with clock enable
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)    enable_q <= 1'b0;
    else if (enable_ce) enable_q <= enable_d;
  end

  // Read data: next state
  always_comb begin
    rdata_d = '0;
    if (rd_req) begin
      case (slot)
        SLOT_ENABLE: rdata_d = {{(DATA_W-1){1'b0}}, enable_q};
        SLOT_CONFIG: rdata_d = cfg_word;
        default:     rdata_d = '0;
      endcase
    end
  end

  // Read data: register
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) rdata_q <= '0;
    else             rdata_q <= rdata_d;
  end

  assign bus_rdata = rdata_q;

  // R2
  enable_write_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_req && slot == SLOT_ENABLE) |=> (enable_q == $past(bus_wdata[0])));

  // R2
  enable_read_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rd_req && slot == SLOT_ENABLE) |=> (bus_rdata == {{(DATA_W-1){1'b0}}, $past(enable_q)}));

  // R3
  config_read_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rd_req && slot == SLOT_CONFIG) |=> (bus_rdata == cfg_word));

  // R3 R4 R5 R6
  enable_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(wr_req && slot == SLOT_ENABLE) |=> $stable(enable_q));

  // R4 R5 R6
  zero_slot_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rd_req && slot != SLOT_ENABLE && slot != SLOT_CONFIG) |=> (bus_rdata == '0));

  // R7
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !rd_req |=> (bus_rdata == '0));

endmodule

// File: tb/test_clu_regblk.sv
module test_clu_regblk;

  localparam int CLK_PERIOD = 10;
  localparam int NCORES     = 3;
  localparam int WATCHDOG   = 100000;

  logic        clk;
  logic        rst_n;
  logic        bus_sel;
  logic        bus_we;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;

  int checks;
  int failures;
  int cycles;

  // Reference model state
  bit          m_enable;
  logic [31:0] m_rdata;

  clu_regblk #(.NUM_CORES(NCORES)) i_clu_regblk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] expected_cfg();
    int w;
    w = (((1 << NCORES) - 1) << 4) | (NCORES - 1);
    return 32'(w);
  endfunction

  function automatic logic [31:0] model_read(logic [7:0] a);
    int off;
    off = int'(a) & 'hFC;
    if (off == 0)      return {31'b0, m_enable};
    else if (off == 4) return expected_cfg();
    else               return 32'h0;
  endfunction

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // One bus cycle: drive at falling edge, update model at rising edge, compare after it
  task automatic cycle(input bit sel, input bit we, input logic [7:0] a,
                       input logic [31:0] d, input string req);
    @(negedge clk);
    bus_sel = sel; bus_we = we; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    if (sel && !we) m_rdata = model_read(a);
    else            m_rdata = 32'h0;
    if (sel && we && ((int'(a) & 'hFC) == 0)) m_enable = d[0];
    #1;
    checks++;
    if (bus_rdata !== m_rdata) begin
      failures++;
      $display("FAIL %s addr=%h we=%0b actual=%h expected=%h", req, a, we, bus_rdata, m_rdata);
    end
  endtask

  task automatic idle(input string req);
    cycle(1'b0, 1'b0, 8'h00, 32'h0, req);
  endtask

  task automatic apply_reset();
    @(negedge clk);
    rst_n = 1'b0; bus_sel = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    m_enable = 1'b0; m_rdata = 32'h0;
    repeat (3) idle("R1");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) idle("R1");
  endtask

  initial begin
    cycles = 0;
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > WATCHDOG) begin
        failures++;
        $display("FAIL watchdog actual=%0d expected<=%0d", cycles, WATCHDOG);
        finish_run();
      end
    end
  end

  initial begin
    checks = 0; failures = 0;
    rst_n = 1'b0; bus_sel = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    m_enable = 1'b0; m_rdata = 32'h0;
    apply_reset();

    // R1: reset state of the enable bit
    cycle(1, 0, 8'h00, 0, "R1");

    // R2: only bit 0 is stored
    cycle(1, 1, 8'h00, 32'hFFFF_FFFF, "R2");
    cycle(1, 0, 8'h00, 0, "R2");
    cycle(1, 1, 8'h00, 32'hFFFF_FFFE, "R2");
    cycle(1, 0, 8'h00, 0, "R2");
    cycle(1, 1, 8'h00, 32'h0000_0001, "R2");
    cycle(1, 0, 8'h00, 0, "R2");

    // R3: configuration word, write ignored
    cycle(1, 0, 8'h04, 0, "R3");
    cycle(1, 1, 8'h04, 32'h0000_0000, "R3");
    cycle(1, 0, 8'h04, 0, "R3");
    cycle(1, 0, 8'h00, 0, "R3");

    // R4 R5 R6: writes with bit0 clear must not touch the enable bit
    cycle(1, 1, 8'h08, 32'hFFFF_FFFE, "R4");
    cycle(1, 1, 8'h0C, 32'hFFFF_FFFE, "R4");
    cycle(1, 0, 8'h00, 0, "R4");
    cycle(1, 0, 8'h08, 0, "R4");
    cycle(1, 0, 8'h0C, 0, "R4");
    cycle(1, 1, 8'h40, 32'hFFFF_FFFE, "R5");
    cycle(1, 1, 8'h44, 32'hFFFF_FFFE, "R5");
    cycle(1, 0, 8'h00, 0, "R5");
    cycle(1, 0, 8'h40, 0, "R5");
    cycle(1, 0, 8'h44, 0, "R5");
    cycle(1, 1, 8'h50, 32'hFFFF_FFFE, "R6");
    cycle(1, 1, 8'h54, 32'hFFFF_FFFE, "R6");
    cycle(1, 1, 8'h80, 32'hFFFF_FFFE, "R6");
    cycle(1, 1, 8'hFC, 32'hFFFF_FFFE, "R6");
    cycle(1, 0, 8'h00, 0, "R6");
    for (int w = 0; w < 64; w++) cycle(1, 0, 8'(w * 4), 0, "R6");

    // R7: zero after idle and after write, valid the cycle after a read
    cycle(1, 0, 8'h04, 0, "R7");
    idle("R7");
    cycle(1, 0, 8'h00, 0, "R7");
    cycle(1, 1, 8'h10, 32'h1234_5678, "R7");
    cycle(1, 0, 8'h04, 0, "R7");
    cycle(1, 0, 8'h04, 0, "R7");

    // R9: byte-lane bits ignored
    cycle(1, 0, 8'h05, 0, "R9");
    cycle(1, 0, 8'h07, 0, "R9");
    cycle(1, 1, 8'h03, 32'h0000_0000, "R9");
    cycle(1, 0, 8'h02, 0, "R9");
    cycle(1, 1, 8'h01, 32'h0000_0001, "R9");
    cycle(1, 0, 8'h00, 0, "R9");
    cycle(1, 1, 8'h09, 32'h0000_0000, "R9");
    cycle(1, 0, 8'h00, 0, "R9");

    // R8: configuration reflects the chosen core count (3 -> 0x72)
    checks++;
    if (expected_cfg() !== 32'h0000_0072) begin
      failures++;
      $display("FAIL R8 actual=%h expected=%h", expected_cfg(), 32'h72);
    end
    cycle(1, 0, 8'h04, 0, "R8");

    // R1: reset mid-run clears the enable bit
    apply_reset();
    cycle(1, 0, 8'h00, 0, "R1");
    idle("R1");

    finish_run();
  end

endmodule